// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block turns a 32-bit single-precision floating-point word into a 16-bit half-precision word. It takes one operand per cycle with a valid strobe and presents the result, together with four exception flags (overflow, underflow, inexact, invalid), one clock later. The output register keeps its contents in cycles with no valid input.

Two result formats can be chosen for each operand. The standard half format keeps infinities and NaNs. The extended-range half format has no infinity or NaN encodings. It uses exponent field 31 as an ordinary binade, so it reaches one exponent step higher and saturates to its largest magnitude instead of to infinity. Four rounding directions and two ways of detecting tininess are selected for each operand.

Inside the block, the operand is unpacked and classified. The discarded low bits are masked with a mask that widens as the value moves into the half subnormal range, and the rounding increment is added. A carry out of the significand is absorbed into the exponent. The result is then checked against the format's limits and packed. Values far below the smallest half subnormal take a short path that only decides between zero and the smallest subnormal.

Top module: `sp2hp_narrow`

## Requirements
- R1: A conversion presented with `in_valid` high appears on `out_bits` and the flags at the next rising clock edge, with `out_valid` high for exactly that cycle. When `in_valid` is low, `out_valid` falls and `out_bits` and the flags hold their previous values. Reset clears all outputs to zero.
- R2: A finite input whose rounded value fits the format is packed with half exponent field = single exponent field - 112 and the top 10 fraction bits. The sign bit always passes through to bit 15.
- R3: `rnd_mode` selects the rounding direction: 0 = nearest with ties to even, 1 = toward plus infinity, 2 = toward minus infinity, 3 = toward zero. Rounding is applied to the discarded bits.
- R4: When rounding carries the significand out of its top bit, the exponent goes up by one. This also covers a subnormal result that rounds up into the smallest normal (0x0400).
- R5: Standard format (`alt_fmt` = 0): a rounded unbiased exponent above 15 gives signed infinity (magnitude 0x7C00) and raises overflow and inexact.
- R6: Extended format (`alt_fmt` = 1): unbiased exponents up to 16 are encoded, with field 31 as a normal binade. Above 16 the result is the signed magnitude 0x7FFF, and overflow and inexact are raised.
- R7: Inputs with unbiased exponent from -24 to -15 produce half subnormal results. They are rounded at the subnormal LSB position.
- R8: Inputs with unbiased exponent below -24 give signed zero or the signed smallest subnormal (magnitude 0x0001), and always raise inexact and underflow. Nearest-even rounds up only for a value strictly above 2^-25. Directed modes round away from zero only in their own direction.
- R9: `tiny_pre` = 1 raises underflow for any finite input whose unbiased exponent is below -14, whether or not the result is exact. `tiny_pre` = 0 raises underflow only when the result is inexact and the rounded exponent is still below -14.
- R10: Standard format: infinity gives signed infinity. A NaN gives field 31 with the top 10 fraction bits and fraction bit 9 forced to 1. A signalling NaN (input fraction bit 22 = 0) raises invalid. No other flag is raised.
- R11: Extended format: an infinity or NaN input gives signed zero and raises invalid only.
- R12: A single-precision zero or subnormal input (exponent field 0) gives signed zero with no flags.
- R13: Inexact is raised exactly when a nonzero bit is discarded, on overflow, or on the deep-tiny path of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 32 | Single-precision operand |
| alt_fmt | input | 1 | 0 = standard half, 1 = extended-range half |
| rnd_mode | input | 2 | Rounding direction (encoding in R3) |
| tiny_pre | input | 1 | 1 = tininess detected before rounding |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_bits | output | 16 | Half-precision result |
| ovf_flag | output | 1 | Overflow |
| unf_flag | output | 1 | Underflow |
| inx_flag | output | 1 | Inexact |
| inv_flag | output | 1 | Invalid operation |

## Verification
Rounding carry and overflow can both happen on the same operand. 65520.0 is exactly halfway above the largest standard half, so nearest-even carries it into exponent 16. That is infinity with overflow in the standard format but a plain inexact 2^16 in the extended format, while toward-zero on the same operand stays at 0x7BFF. Carry and tininess also meet on one operand: a value just below 2^-14 rounds up into the smallest normal. Its underflow flag is judged against both tininess settings.

// File: rtl/sp2hp_pkg.sv
`timescale 1ns/1ps
// Shared format constants and types for the single-to-half converter.
// Assumes IEEE-style layouts: sign on top, biased exponent, fraction.
package sp2hp_pkg;
    localparam int SP_EW   = 8;
    localparam int SP_FW   = 23;
    localparam int HP_EW   = 5;
    localparam int HP_FW   = 10;
    localparam int SP_W    = 1 + SP_EW + SP_FW;
    localparam int HP_W    = 1 + HP_EW + HP_FW;
    localparam int SIG_W   = SP_FW + 1;            // significand with implicit one
    localparam int DROP    = SP_FW - HP_FW;        // bits dropped for a normal result
    localparam int SH_W    = $clog2(SIG_W);
    localparam int EXP_W   = SP_EW + 2;            // signed working exponent
    localparam int SP_BIAS = (1 << (SP_EW - 1)) - 1;
    localparam int HP_BIAS = (1 << (HP_EW - 1)) - 1;
    localparam int HP_EMIN = 1 - HP_BIAS;          // smallest normal exponent
    localparam int HP_EMAX = HP_BIAS;              // largest standard exponent
    localparam int HP_ELO  = HP_EMIN - HP_FW;      // smallest subnormal exponent

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_UP        = 2'd1,
        RND_DOWN      = 2'd2,
        RND_ZERO      = 2'd3
    } rnd_e;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_FINITE, CLS_INF, CLS_QNAN, CLS_SNAN
    } cls_e;

    typedef struct packed {
        logic                     sign;
        cls_e                     cls;
        logic signed [EXP_W-1:0]  uexp;
        logic [SIG_W-1:0]         sig;
    } unp_t;
endpackage

// File: rtl/sp2hp_unpack.sv
`timescale 1ns/1ps
// Splits a single-precision word into sign, class, unbiased exponent and
// significand with the implicit one restored. Exponent field 0 (zero or
// subnormal) is classed as zero; its significand is not used downstream.
module sp2hp_unpack
    import sp2hp_pkg::*;
(
    input  logic [SP_W-1:0] val,
    output unp_t            u
);
    logic [SP_EW-1:0] efld;
    logic [SP_FW-1:0] frac;

    // Field extraction and classification.
    always_comb begin
        efld   = val[SP_W-2 -: SP_EW];
        frac   = val[SP_FW-1:0];
        u.sign = val[SP_W-1];
        u.sig  = {1'b1, frac};
        u.uexp = $signed({{(EXP_W-SP_EW){1'b0}}, efld}) - EXP_W'(SP_BIAS);
        if (efld == '1)
            u.cls = (frac == '0) ? CLS_INF : (frac[SP_FW-1] ? CLS_QNAN : CLS_SNAN);
        else if (efld == '0)
            u.cls = CLS_ZERO;
        else
            u.cls = CLS_FINITE;
    end
endmodule

// File: rtl/sp2hp_round.sv
`timescale 1ns/1ps
// Builds the discard mask for the target binade, adds the rounding
// increment and folds a significand carry into the exponent. Exponents
// below the subnormal range are flagged as "deep"; for them only the
// choice between zero and the smallest subnormal is produced.
module sp2hp_round
    import sp2hp_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] uexp,
    input  logic [SIG_W-1:0]        sig,
    input  logic [1:0]              rmode,
    output logic [SIG_W-1:0]        rsig,
    output logic signed [EXP_W-1:0] rexp,
    output logic                    inexact,
    output logic                    deep,
    output logic                    deep_up
);
    localparam logic signed [EXP_W-1:0] E_NMIN = EXP_W'(HP_EMIN);
    localparam logic signed [EXP_W-1:0] E_LO   = EXP_W'(HP_ELO);
    localparam logic signed [EXP_W-1:0] E_HALF = EXP_W'(HP_ELO - 1);
    localparam logic signed [EXP_W-1:0] E_ONE  = EXP_W'(1);
    localparam logic [SIG_W-1:0] MASK_NORM = SIG_W'((1 << DROP) - 1);
    localparam logic [SIG_W-1:0] MASK_FULL = {1'b0, {SP_FW{1'b1}}};

    logic [SIG_W-1:0] mask, lsb, half, rem, inc;
    logic [SIG_W:0]   sum;
    logic [SH_W-1:0]  sh;
    rnd_e             rm;

    // Discard mask selection from the unbiased exponent.
    always_comb begin
        deep = uexp < E_LO;
        sh   = SH_W'(uexp - E_LO);
        if (uexp >= E_NMIN) mask = MASK_NORM;
        else if (!deep)     mask = MASK_FULL >> sh;
        else                mask = MASK_FULL;
        lsb  = mask + SIG_W'(1);
        half = lsb >> 1;
        rem  = sig & mask;
    end

    // Rounding increment per direction.
    always_comb begin
        rm = rnd_e'(rmode);
        case (rm)
            RND_NEAR_EVEN: inc = (rem == half) ? (sig & lsb) : half;
            RND_UP:        inc = sign ? '0 : mask;
            RND_DOWN:      inc = sign ? mask : '0;
            default:       inc = '0;
        endcase
    end

    // Increment, carry fold-back and deep-tiny decision.
    always_comb begin
        sum = {1'b0, sig} + {1'b0, inc};
        if (sum[SIG_W]) begin
            rsig = sum[SIG_W:1];
            rexp = uexp + E_ONE;
        end else begin
            rsig = sum[SIG_W-1:0];
            rexp = uexp;
        end
        inexact = (rem != '0) || deep;
        case (rm)
            RND_NEAR_EVEN: deep_up = (uexp == E_HALF) && (sig[SP_FW-1:0] != '0);
            RND_UP:        deep_up = !sign;
            RND_DOWN:      deep_up = sign;
            default:       deep_up = 1'b0;
        endcase
    end
endmodule

// File: rtl/sp2hp_pack.sv
`timescale 1ns/1ps
// Applies the format limits (infinity or saturation), aligns subnormal
// results, packs the half word and forms the four flags. The implicit
// bit of the significand is added into the exponent field, so a round-up
// into the next binade needs no separate adjustment.
module sp2hp_pack
    import sp2hp_pkg::*;
(
    input  logic                    sign,
    input  cls_e                    cls,
    input  logic [HP_FW-1:0]        nan_frac,
    input  logic signed [EXP_W-1:0] uexp,
    input  logic [SIG_W-1:0]        rsig,
    input  logic signed [EXP_W-1:0] rexp,
    input  logic                    inexact,
    input  logic                    deep,
    input  logic                    deep_up,
    input  logic                    alt,
    input  logic                    tiny_pre,
    output logic [HP_W-1:0]         res,
    output logic                    ovf,
    output logic                    unf,
    output logic                    inx,
    output logic                    inv
);
    localparam logic signed [EXP_W-1:0] E_NMIN  = EXP_W'(HP_EMIN);
    localparam logic signed [EXP_W-1:0] E_MAX_S = EXP_W'(HP_EMAX);
    localparam logic signed [EXP_W-1:0] E_MAX_A = EXP_W'(HP_EMAX + 1);

    logic signed [EXP_W-1:0] emax;
    logic [SIG_W-1:0]        ssig;
    logic [HP_EW-1:0]        efld;
    logic [HP_W-2:0]         mag;
    logic [HP_FW-1:0]        qfrac;

    // Subnormal alignment and field addition for finite results.
    always_comb begin
        emax = alt ? E_MAX_A : E_MAX_S;
        if (rexp < E_NMIN) begin
            ssig = rsig >> SH_W'(E_NMIN - rexp);
            efld = '0;
        end else begin
            ssig = rsig;
            efld = HP_EW'(rexp - E_NMIN);
        end
        mag = {efld, {HP_FW{1'b0}}} + (HP_W-1)'(ssig >> DROP);
        qfrac = nan_frac;
        if (cls != CLS_INF) qfrac[HP_FW-1] = 1'b1;
    end

    // Result selection by class and range, with flags.
    always_comb begin
        res = {sign, {(HP_W-1){1'b0}}};
        ovf = 1'b0;
        unf = 1'b0;
        inx = 1'b0;
        inv = 1'b0;
        case (cls)
            CLS_ZERO: ;
            CLS_INF, CLS_QNAN, CLS_SNAN: begin
                if (alt) inv = 1'b1;
                else begin
                    res = {sign, {HP_EW{1'b1}}, qfrac};
                    inv = (cls == CLS_SNAN);
                end
            end
            default: begin
                if (deep) begin
                    res = {sign, (HP_W-1)'(deep_up)};
                    inx = 1'b1;
                    unf = 1'b1;
                end else if (rexp > emax) begin
                    ovf = 1'b1;
                    inx = 1'b1;
                    res = alt ? {sign, {(HP_W-1){1'b1}}}
                              : {sign, {HP_EW{1'b1}}, {HP_FW{1'b0}}};
                end else begin
                    res = {sign, mag};
                    inx = inexact;
                    unf = tiny_pre ? (uexp < E_NMIN) : (inexact && (rexp < E_NMIN));
                end
            end
        endcase
    end
endmodule

// File: rtl/sp2hp_narrow.sv
`timescale 1ns/1ps
// Top level: single-precision to half-precision narrowing converter with
// one register stage. The datapath is combinational from in_bits to the
// output register; results and flags load only on in_valid and hold
// otherwise. Assumes rnd_mode, alt_fmt and tiny_pre are valid with in_bits.
module sp2hp_narrow
    import sp2hp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [SP_W-1:0] in_bits,
    input  logic            alt_fmt,
    input  logic [1:0]      rnd_mode,
    input  logic            tiny_pre,
    output logic            out_valid,
    output logic [HP_W-1:0] out_bits,
    output logic            ovf_flag,
    output logic            unf_flag,
    output logic            inx_flag,
    output logic            inv_flag
);
    unp_t                    u;
    logic [SIG_W-1:0]        rsig;
    logic signed [EXP_W-1:0] rexp;
    logic                    inexact, deep, deep_up;
    logic [HP_W-1:0]         res;
    logic                    ovf, unf, inx, inv;

    sp2hp_unpack u_unpack (.val(in_bits), .u(u));

    sp2hp_round u_round (
        .sign(u.sign), .uexp(u.uexp), .sig(u.sig), .rmode(rnd_mode),
        .rsig(rsig), .rexp(rexp), .inexact(inexact), .deep(deep), .deep_up(deep_up)
    );

    sp2hp_pack u_pack (
        .sign(u.sign), .cls(u.cls), .nan_frac(u.sig[SP_FW-1 -: HP_FW]),
        .uexp(u.uexp), .rsig(rsig), .rexp(rexp), .inexact(inexact),
        .deep(deep), .deep_up(deep_up), .alt(alt_fmt), .tiny_pre(tiny_pre),
        .res(res), .ovf(ovf), .unf(unf), .inx(inx), .inv(inv)
    );

    // Output register: strobe every cycle, data and flags on valid only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
            inx_flag  <= 1'b0;
            inv_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bits <= res;
                ovf_flag <= ovf;
                unf_flag <= unf;
                inx_flag <= inx;
                inv_flag <= inv;
            end
        end
    end
endmodule

// Checker: port-level properties of the converter, bound to the top.
// Assumes the bound instance uses the package layout constants.
module sp2hp_narrow_chk
    import sp2hp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [SP_W-1:0] in_bits,
    input logic            alt_fmt,
    input logic            out_valid,
    input logic [HP_W-1:0] out_bits,
    input logic            ovf_flag,
    input logic            unf_flag,
    input logic            inx_flag,
    input logic            inv_flag
);
    logic in_nonfinite, in_nan, in_zero;

    // Input classification seen at the ports.
    always_comb begin
        in_nonfinite = in_bits[SP_W-2 -: SP_EW] == '1;
        in_nan       = in_nonfinite && (in_bits[SP_FW-1:0] != '0);
        in_zero      = in_bits[SP_W-2 -: SP_EW] == '0;
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_bits) && $stable(inx_flag)));
    a_r2_sign_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_bits[HP_W-1] == $past(in_bits[SP_W-1]));
    a_r5_std_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag && !$past(alt_fmt)) |-> (out_bits[HP_W-2:0] == 15'h7c00 && inx_flag));
    a_r6_alt_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag && $past(alt_fmt)) |-> (out_bits[HP_W-2:0] == 15'h7fff && inx_flag));
    a_r9_unf_small: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf_flag) |-> (out_bits[HP_W-2:HP_FW+1] == '0));
    a_r10_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !alt_fmt && in_nan) |=> (out_bits[HP_W-2:HP_FW-1] == '1 && !ovf_flag && !inx_flag));
    a_r11_alt_nonfinite: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && alt_fmt && in_nonfinite) |=> (inv_flag && out_bits[HP_W-2:0] == '0 && !ovf_flag));
    a_r12_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero) |=> (out_bits[HP_W-2:0] == '0 && !ovf_flag && !unf_flag && !inx_flag && !inv_flag));
endmodule

bind sp2hp_narrow sp2hp_narrow_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .alt_fmt(alt_fmt), .out_valid(out_valid), .out_bits(out_bits),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .inx_flag(inx_flag),
    .inv_flag(inv_flag)
);

// File: tb/sim_sp2hp_narrow.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
// Flag vectors below are ordered {ovf, unf, inx, inv}.
module sim_sp2hp_narrow;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        alt_fmt = 1'b0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        tiny_pre = 1'b0;
    logic        out_valid;
    logic [15:0] out_bits;
    logic        ovf_flag, unf_flag, inx_flag, inv_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    localparam logic [1:0] NE = 2'd0, UP = 2'd1, DN = 2'd2, TZ = 2'd3;

    always #2.5 clk = ~clk;

    sp2hp_narrow u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .alt_fmt(alt_fmt), .rnd_mode(rnd_mode), .tiny_pre(tiny_pre),
        .out_valid(out_valid), .out_bits(out_bits), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .inx_flag(inx_flag), .inv_flag(inv_flag)
    );

    task automatic conv(input string req, input logic [31:0] x, input bit alt,
                        input logic [1:0] rm, input bit tp,
                        input logic [15:0] eb, input logic [3:0] ef);
        logic [3:0] gf;
        @(negedge clk);
        in_bits = x; alt_fmt = alt; rnd_mode = rm; tiny_pre = tp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        gf = {ovf_flag, unf_flag, inx_flag, inv_flag};
        n_chk++;
        if (out_valid !== 1'b1 || out_bits !== eb || gf !== ef) begin
            n_fail++;
            $display("FAIL %s: in=%h alt=%0d rm=%0d tp=%0d got bits=%h flags=%b valid=%b expected bits=%h flags=%b valid=1",
                     req, x, alt, rm, tp, out_bits, gf, out_valid, eb, ef);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_bits !== 16'h0 ||
            {ovf_flag, unf_flag, inx_flag, inv_flag} !== 4'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got valid=%b bits=%h flags=%b expected 0 0000 0000",
                     out_valid, out_bits, {ovf_flag, unf_flag, inx_flag, inv_flag});
        end
    endtask

    task automatic t_hold();
        conv("R1 load", 32'h3F800001, 1'b0, UP, 1'b0, 16'h3C01, 4'b0010);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_bits = 32'h7F800001 + i; alt_fmt = 1'b1;
            n_chk++;
            if (out_valid !== 1'b0 || out_bits !== 16'h3C01 ||
                {ovf_flag, unf_flag, inx_flag, inv_flag} !== 4'b0010) begin
                n_fail++;
                $display("FAIL R1 hold: got valid=%b bits=%h flags=%b expected 0 3c01 0010",
                         out_valid, out_bits, {ovf_flag, unf_flag, inx_flag, inv_flag});
            end
        end
        alt_fmt = 1'b0;
    endtask

    task automatic t_normal();
        conv("R2 one",      32'h3F800000, 1'b0, NE, 1'b0, 16'h3C00, 4'b0000);
        conv("R2 neg",      32'hC0200000, 1'b0, NE, 1'b0, 16'hC100, 4'b0000);
        conv("R2 max std",  32'h477FE000, 1'b0, NE, 1'b0, 16'h7BFF, 4'b0000);
    endtask

    task automatic t_round_modes();
        conv("R3 tie even down", 32'h3F801000, 1'b0, NE, 1'b0, 16'h3C00, 4'b0010);
        conv("R3 tie even up",   32'h3F803000, 1'b0, NE, 1'b0, 16'h3C02, 4'b0010);
        conv("R3 up pos",        32'h3F800001, 1'b0, UP, 1'b0, 16'h3C01, 4'b0010);
        conv("R3 down pos",      32'h3F800001, 1'b0, DN, 1'b0, 16'h3C00, 4'b0010);
        conv("R3 zero pos",      32'h3F800001, 1'b0, TZ, 1'b0, 16'h3C00, 4'b0010);
        conv("R3 up neg",        32'hBF800001, 1'b0, UP, 1'b0, 16'hBC00, 4'b0010);
        conv("R13 down neg",     32'hBF800001, 1'b0, DN, 1'b0, 16'hBC01, 4'b0010);
    endtask

    task automatic t_carry_ovf();
        conv("R4 R5 carry to inf",   32'h477FF000, 1'b0, NE, 1'b0, 16'h7C00, 4'b1010);
        conv("R3 zero no carry",     32'h477FF000, 1'b0, TZ, 1'b0, 16'h7BFF, 4'b0010);
        conv("R5 exact 2^16 std",    32'h47800000, 1'b0, NE, 1'b0, 16'h7C00, 4'b1010);
        conv("R5 neg big std",       32'hC8000000, 1'b0, TZ, 1'b0, 16'hFC00, 4'b1010);
    endtask

    task automatic t_alt();
        conv("R6 R4 carry alt",   32'h477FF000, 1'b1, NE, 1'b0, 16'h7C00, 4'b0010);
        conv("R6 exact 2^16 alt", 32'h47800000, 1'b1, NE, 1'b0, 16'h7C00, 4'b0000);
        conv("R6 sat pos",        32'h48000000, 1'b1, NE, 1'b0, 16'h7FFF, 4'b1010);
        conv("R6 sat neg",        32'hC8000000, 1'b1, UP, 1'b0, 16'hFFFF, 4'b1010);
    endtask

    task automatic t_subnormal();
        conv("R7 2^-15",         32'h38000000, 1'b0, NE, 1'b0, 16'h0200, 4'b0000);
        conv("R7 min sub",       32'h33800000, 1'b0, NE, 1'b0, 16'h0001, 4'b0000);
        conv("R7 tie to 2",      32'h33C00000, 1'b0, NE, 1'b0, 16'h0002, 4'b0110);
        conv("R4 into min norm", 32'h387FFFFF, 1'b0, NE, 1'b0, 16'h0400, 4'b0010);
    endtask

    task automatic t_tiny_mode();
        conv("R9 pre exact",     32'h33800000, 1'b0, NE, 1'b1, 16'h0001, 4'b0100);
        conv("R9 pre carry",     32'h387FFFFF, 1'b0, NE, 1'b1, 16'h0400, 4'b0110);
        conv("R9 pre normal",    32'h38800000, 1'b0, NE, 1'b1, 16'h0400, 4'b0000);
    endtask

    task automatic t_deep();
        conv("R8 half tie",      32'h33000000, 1'b0, NE, 1'b0, 16'h0000, 4'b0110);
        conv("R8 above half",    32'h33400000, 1'b0, NE, 1'b0, 16'h0001, 4'b0110);
        conv("R8 quarter",       32'h32800000, 1'b0, NE, 1'b0, 16'h0000, 4'b0110);
        conv("R8 up pos",        32'h33000000, 1'b0, UP, 1'b0, 16'h0001, 4'b0110);
        conv("R8 down neg",      32'hB3000000, 1'b0, DN, 1'b0, 16'h8001, 4'b0110);
        conv("R8 zero neg",      32'hB3000000, 1'b0, TZ, 1'b0, 16'h8000, 4'b0110);
    endtask

    task automatic t_nonfinite();
        conv("R10 inf",       32'h7F800000, 1'b0, NE, 1'b0, 16'h7C00, 4'b0000);
        conv("R10 neg inf",   32'hFF800000, 1'b0, NE, 1'b0, 16'hFC00, 4'b0000);
        conv("R10 qnan",      32'h7FC00000, 1'b0, NE, 1'b0, 16'h7E00, 4'b0000);
        conv("R10 snan",      32'h7F800001, 1'b0, NE, 1'b0, 16'h7E00, 4'b0001);
        conv("R10 snan pay",  32'hFF802000, 1'b0, NE, 1'b0, 16'hFE01, 4'b0001);
        conv("R11 alt inf",   32'h7F800000, 1'b1, NE, 1'b0, 16'h0000, 4'b0001);
        conv("R11 alt nan",   32'hFFC00000, 1'b1, NE, 1'b0, 16'h8000, 4'b0001);
    endtask

    task automatic t_zero();
        conv("R12 neg zero",  32'h80000000, 1'b0, NE, 1'b1, 16'h8000, 4'b0000);
        conv("R12 sub pos",   32'h00000001, 1'b0, UP, 1'b0, 16'h0000, 4'b0000);
        conv("R12 sub neg",   32'h807FFFFF, 1'b1, DN, 1'b1, 16'h8000, 4'b0000);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_normal();
        t_round_modes();
        t_carry_ovf();
        t_alt();
        t_subnormal();
        t_tiny_mode();
        t_deep();
        t_nonfinite();
        t_zero();
        t_hold();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule